// File: doc/BRIEF.md
# Taken-Only Branch Target Buffer

This block sits in the fetch stage and proposes the next fetch address every cycle, before the fetched instruction has been decoded. The current fetch PC is looked up in a direct-mapped table of tagged entries. If an entry's tag matches, the stored target becomes the next fetch PC, and the hit by itself means "predicted taken". If no entry matches, fetch continues sequentially at PC+4.

The table only learns from resolved control transfers. When the execute stage resolves a branch or jump, it presents the branch PC, whether it was taken and where it went. A taken resolution writes or overwrites the entry with the actual target. Register-indirect jumps are handled the same way, so they can also be redirected early. A not-taken resolution that hits the table evicts the entry. Non-branch instructions never present an update. In the same cycle the block reports whether the table's answer for that PC disagreed with the resolved outcome, and it gives the corrected next PC so that fetch can kill the wrongly fetched instructions and restart.

With the default parameters the table has 16 entries indexed by PC bits [5:2]. PC bits [31:6] are the tag, and each entry has a valid bit.

Top module: `taken_btb`

## Requirements
- R1: When `fetch_pc` matches a valid entry (same index PC[IDX_W+1:2], same tag PC[31:IDX_W+2]), `pred_hit` is 1 and `pred_next_pc` equals the stored target, in the same cycle with no register in the path.
- R2: When `fetch_pc` matches no valid entry, `pred_hit` is 0 and `pred_next_pc` equals `fetch_pc + 4`.
- R3: A cycle with `res_valid`=1 and `res_taken`=1 writes the entry for `res_pc` with tag and `res_target`, replacing whatever target was there. From the next cycle, a lookup of `res_pc` hits with that target. Any 32-bit target is accepted, including register-indirect destinations.
- R4: A cycle with `res_valid`=1 and `res_taken`=0 clears the entry for `res_pc` only if it currently hits. A different PC that shares the index is left valid and unchanged.
- R5: While `res_valid`=0, the table is not changed and `res_mispredict` is 0, whatever the other resolve inputs hold.
- R6: Synchronous active-high `rst` clears every valid bit, so after reset every lookup misses.
- R7: `res_mispredict` is 1 in three cases: a taken resolution that misses, a taken resolution that hits with a stored target different from `res_target`, and a not-taken resolution that hits. A taken hit with an equal target gives 0, and so does a not-taken miss.
- R8: `res_correct_pc` is `res_target` when `res_taken`=1, and `res_pc + 4` otherwise.
- R9: Two PCs with the same index but different tags do not hit each other's entry. Allocating one replaces the other.
- R10: A lookup in the same cycle as an update to the same entry sees the contents from before the update. The new contents are visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Current fetch address |
| pred_hit | output | 1 | Lookup hit, meaning predicted taken |
| pred_next_pc | output | 32 | Proposed next fetch address |
| res_valid | input | 1 | A resolved branch or jump is presented |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | 32 | Actual target address |
| res_mispredict | output | 1 | Table answer disagreed with the resolution |
| res_correct_pc | output | 32 | Address at which fetch should restart |

## Verification
The lookup is driven with addresses the table has never seen, with PCs just allocated, and with PCs that share an index with a stored entry but differ in tag. These three cases separate a true tag compare from an index-only match. Resolutions cover all four combinations of taken or not-taken against hit or miss, plus a taken hit with a changed target, so each mispredict cause and each non-cause is checked separately. An update and a lookup of the same PC in one cycle show the old-versus-new read order. A reset in the middle of the run, and a resolve port carrying data while `res_valid` is low, show that entries are cleared only by reset and by hitting not-taken resolutions.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int PC_W       = 32;
    localparam int INSN_BYTES = 4;
    localparam int ALIGN_W    = 2;

    typedef logic [PC_W-1:0] pc_t;

    // Result of comparing one PC against one table slot
    typedef struct packed {
        logic hit;
        pc_t  target;
    } probe_t;

    // One resolved control transfer from the execute stage
    typedef struct packed {
        logic valid;
        logic taken;
        pc_t  pc;
        pc_t  target;
    } resolve_t;

    // Table write request
    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_FILL  = 2'd1,
        WR_EVICT = 2'd2
    } wr_op_e;

    function automatic pc_t seq_pc(input pc_t pc);
        return pc + pc_t'(INSN_BYTES);
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int NRD   = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [IDX_W-1:0]               rd_idx   [NRD],
    output logic                           rd_valid [NRD],
    output logic [PC_W-IDX_W-ALIGN_W-1:0]  rd_tag   [NRD],
    output pc_t                            rd_tgt   [NRD],
    input  wr_op_e                         wr_op,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [PC_W-IDX_W-ALIGN_W-1:0]  wr_tag,
    input  pc_t                            wr_tgt
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W - ALIGN_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];
    pc_t              tgt_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            case (wr_op)
                WR_FILL:  valid_q[wr_idx] <= 1'b1;
                WR_EVICT: valid_q[wr_idx] <= 1'b0;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr_op == WR_FILL) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_valid[p] = valid_q[rd_idx[p]];
        assign rd_tag[p]   = tag_q[rd_idx[p]];
        assign rd_tgt[p]   = tgt_q[rd_idx[p]];
    end

endmodule

// File: rtl/btb_match.sv
module btb_match
    import btb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  pc_t                           pc,
    output logic [IDX_W-1:0]              idx,
    output logic [PC_W-IDX_W-ALIGN_W-1:0] tag,
    input  logic                          slot_valid,
    input  logic [PC_W-IDX_W-ALIGN_W-1:0] slot_tag,
    input  pc_t                           slot_tgt,
    output probe_t                        probe
);

    assign idx = pc[IDX_W+ALIGN_W-1:ALIGN_W];
    assign tag = pc[PC_W-1:IDX_W+ALIGN_W];

    always_comb begin
        probe.hit    = slot_valid && (slot_tag == tag);
        probe.target = slot_tgt;
    end

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
    import btb_pkg::*;
(
    input  resolve_t res,
    input  probe_t   probe,
    output wr_op_e   wr_op,
    output logic     mispredict,
    output pc_t      correct_pc
);

    logic tgt_diff;

    always_comb begin
        tgt_diff   = probe.target != res.target;
        wr_op      = WR_NONE;
        mispredict = 1'b0;
        if (res.valid) begin
            if (res.taken) begin
                wr_op      = WR_FILL;
                mispredict = !probe.hit || tgt_diff;
            end else if (probe.hit) begin
                wr_op      = WR_EVICT;
                mispredict = 1'b1;
            end
        end
        correct_pc = res.taken ? res.target : seq_pc(res.pc);
    end

endmodule

// File: rtl/taken_btb.sv
module taken_btb
    import btb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     fetch_pc,
    output logic            pred_hit,
    output logic [31:0]     pred_next_pc,
    input  logic            res_valid,
    input  logic [31:0]     res_pc,
    input  logic            res_taken,
    input  logic [31:0]     res_target,
    output logic            res_mispredict,
    output logic [31:0]     res_correct_pc
);

    localparam int TAG_W = PC_W - IDX_W - ALIGN_W;
    localparam int NRD   = 2;
    localparam int P_FET = 0;
    localparam int P_RES = 1;

    logic [IDX_W-1:0] rd_idx   [NRD];
    logic             rd_valid [NRD];
    logic [TAG_W-1:0] rd_tag   [NRD];
    pc_t              rd_tgt   [NRD];
    logic [TAG_W-1:0] cmp_tag  [NRD];
    probe_t           probe    [NRD];
    pc_t              probe_pc [NRD];

    wr_op_e   wr_op;
    resolve_t res;

    assign res.valid  = res_valid;
    assign res.taken  = res_taken;
    assign res.pc     = res_pc;
    assign res.target = res_target;

    assign probe_pc[P_FET] = fetch_pc;
    assign probe_pc[P_RES] = res_pc;

    for (genvar p = 0; p < NRD; p++) begin : g_port
        btb_match #(.IDX_W(IDX_W)) u_match (
            .pc         (probe_pc[p]),
            .idx        (rd_idx[p]),
            .tag        (cmp_tag[p]),
            .slot_valid (rd_valid[p]),
            .slot_tag   (rd_tag[p]),
            .slot_tgt   (rd_tgt[p]),
            .probe      (probe[p])
        );
    end

    btb_store #(.IDX_W(IDX_W), .NRD(NRD)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_tgt   (rd_tgt),
        .wr_op    (wr_op),
        .wr_idx   (rd_idx[P_RES]),
        .wr_tag   (cmp_tag[P_RES]),
        .wr_tgt   (res_target)
    );

    btb_resolve u_resolve (
        .res        (res),
        .probe      (probe[P_RES]),
        .wr_op      (wr_op),
        .mispredict (res_mispredict),
        .correct_pc (res_correct_pc)
    );

    assign pred_hit     = probe[P_FET].hit;
    assign pred_next_pc = probe[P_FET].hit ? probe[P_FET].target : seq_pc(fetch_pc);

endmodule

// File: rtl/taken_btb_chk.sv
module taken_btb_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] fetch_pc,
    input logic        pred_hit,
    input logic [31:0] pred_next_pc,
    input logic        res_valid,
    input logic [31:0] res_pc,
    input logic        res_taken,
    input logic [31:0] res_target,
    input logic        res_mispredict,
    input logic [31:0] res_correct_pc
);

    assert_miss_seq_R2: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> pred_next_pc == fetch_pc + 32'd4);

    assert_fill_visible_R3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken) |=>
            (fetch_pc != $past(res_pc)) || (pred_hit && pred_next_pc == $past(res_target)));

    assert_evict_visible_R4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_taken) |=> (fetch_pc != $past(res_pc)) || !pred_hit);

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_mispredict);

    assert_reset_empty_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred_hit);

    assert_taken_refill_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken && res_mispredict) |=>
            (fetch_pc != $past(res_pc)) || pred_hit);

    assert_restart_pc_R8: assert property (@(posedge clk) disable iff (rst)
        res_mispredict |-> res_correct_pc == (res_taken ? res_target : res_pc + 32'd4));

endmodule

bind taken_btb taken_btb_chk u_chk (.*);

// File: tb/sim_taken_btb.sv
`timescale 1ns/1ps
module sim_taken_btb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = 32'h0;
    logic        pred_hit;
    logic [31:0] pred_next_pc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = 32'h0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = 32'h0;
    logic        res_mispredict;
    logic [31:0] res_correct_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    taken_btb u0 (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] pc, input bit exp_hit, input logic [31:0] exp_next, input string req);
        @(negedge clk);
        fetch_pc = pc;
        #0.5;
        check(pred_hit == exp_hit, {req, " hit"}, 32'(pred_hit), 32'(exp_hit));
        check(pred_next_pc == exp_next, {req, " next_pc"}, pred_next_pc, exp_next);
    endtask

    task automatic resolve(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                           input bit exp_mis, input string req);
        logic [31:0] exp_cpc;
        exp_cpc = tk ? tgt : pc + 32'd4;
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
        #0.5;
        check(res_mispredict == exp_mis, {req, " mispredict"}, 32'(res_mispredict), 32'(exp_mis));
        check(res_correct_pc == exp_cpc, {"R8 ", req, " correct_pc"}, res_correct_pc, exp_cpc);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        res_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_empty();
        do_reset();
        lookup(32'h0000_1000, 1'b0, 32'h0000_1004, "R6 R2 empty a");
        lookup(32'hFFFF_FFF0, 1'b0, 32'hFFFF_FFF4, "R6 R2 empty b");
    endtask

    task automatic t_allocate();
        resolve(32'h0000_1000, 1'b1, 32'h0000_2000, 1'b1, "R7 taken miss");
        lookup(32'h0000_1000, 1'b1, 32'h0000_2000, "R1 R3 alloc");
        resolve(32'h0000_1000, 1'b1, 32'h0000_2000, 1'b0, "R7 taken hit same tgt");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fetch_pc = 32'h0000_1108;
        res_valid = 1'b1; res_pc = 32'h0000_1108; res_taken = 1'b1; res_target = 32'h0000_3000;
        #0.5;
        check(pred_hit == 1'b0, "R10 old contents hit", 32'(pred_hit), 32'h0);
        check(pred_next_pc == 32'h0000_110C, "R10 old contents next", pred_next_pc, 32'h0000_110C);
        @(posedge clk);
        #0.5;
        res_valid = 1'b0;
        check(pred_hit == 1'b1, "R10 new contents hit", 32'(pred_hit), 32'h1);
        check(pred_next_pc == 32'h0000_3000, "R10 new contents next", pred_next_pc, 32'h0000_3000);
    endtask

    task automatic t_retarget();
        resolve(32'h0000_1000, 1'b1, 32'h0000_2404, 1'b1, "R7 taken hit new tgt");
        lookup(32'h0000_1000, 1'b1, 32'h0000_2404, "R3 overwrite indirect");
    endtask

    task automatic t_alias();
        lookup(32'h0000_1040, 1'b0, 32'h0000_1044, "R9 alias miss");
        resolve(32'h0000_1040, 1'b0, 32'h0000_9999, 1'b0, "R7 not-taken miss");
        lookup(32'h0000_1000, 1'b1, 32'h0000_2404, "R4 neighbour kept");
        resolve(32'h0000_1040, 1'b1, 32'h0000_5000, 1'b1, "R9 alias alloc");
        lookup(32'h0000_1000, 1'b0, 32'h0000_1004, "R9 replaced");
        lookup(32'h0000_1040, 1'b1, 32'h0000_5000, "R9 new owner");
    endtask

    task automatic t_evict();
        resolve(32'h0000_1040, 1'b0, 32'h0000_5000, 1'b1, "R7 R4 not-taken hit");
        lookup(32'h0000_1040, 1'b0, 32'h0000_1044, "R4 evicted");
    endtask

    task automatic t_idle();
        @(negedge clk);
        res_valid = 1'b0; res_pc = 32'h0000_1108; res_taken = 1'b0; res_target = 32'h0000_7777;
        #0.5;
        check(res_mispredict == 1'b0, "R5 idle mispredict", 32'(res_mispredict), 32'h0);
        @(negedge clk);
        res_taken = 1'b1; res_pc = 32'h0000_1200;
        @(negedge clk);
        lookup(32'h0000_1108, 1'b1, 32'h0000_3000, "R5 entry untouched");
        lookup(32'h0000_1200, 1'b0, 32'h0000_1204, "R5 no fill");
    endtask

    task automatic t_reset_again();
        do_reset();
        lookup(32'h0000_1108, 1'b0, 32'h0000_110C, "R6 cleared");
    endtask

    initial begin
        t_reset_empty();
        t_allocate();
        t_same_cycle();
        t_retarget();
        t_alias();
        t_evict();
        t_idle();
        t_reset_again();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule